// File: doc/BRIEF.md
# Upwind Level-Set Node Update Pipeline

This block advances one grid node of a 2D level-set field by one explicit time step. Each cycle it accepts a node's current value, the values of its four axis neighbours (west, east, north, south), the node's speed and a mask marking which of those neighbours lie beyond the image edge. It returns the node's next value a fixed number of cycles later. The surrounding system fetches neighbours, streams nodes and handles memory. This block is only the arithmetic engine.

The update works in stages. Each neighbour yields a one-sided difference against the centre, clipped so that it is never negative. The largest of the four clipped differences is the discrete norm. The norm times the speed is a full-width product. That product, scaled down by a fixed-point step, moves the centre value down or up, depending on a direction input. Every intermediate value keeps its full precision. Rounding and saturation to the stored width happen once, at the very end.

A valid flag travels with each result. The number of register stages is a parameter, and it changes only the latency, never the value.

Top module: `lsu_node_update`

## Requirements
- R1: For each neighbour the difference term is the centre value minus that neighbour's value, or 0 when this difference would be negative.
- R2: Bit i of `edge_i` forces neighbour i's term to 0. Bit 0 is west, bit 1 east, bit 2 north, bit 3 south.
- R3: The norm is the largest of the four terms.
- R4: The product P = speed × norm is kept at its full 2·DW bits. The result is floor((centre·2^FRAC − P + 2^(FRAC−1)) / 2^FRAC) when `grow_i` is 0, and the same expression with +P when `grow_i` is 1. This is round-half-up, with FRAC = 8 by default.
- R5: The result saturates to 0 below range and to 2^DW−1 (4095) above range. It never wraps.
- R6: When the speed is 0, or when every term is 0, the result equals the centre value.
- R7: `vld_o` is `vld_i` delayed by exactly STAGES clock cycles, and `value_o` carries the result of the inputs sampled with it.
- R8: For every STAGES from 1 to 8 the results are identical. Only the latency differs.
- R9: While `rst_n` is low, `vld_o` and `value_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Input node is valid |
| centre_i | input | DW | Current value of the node |
| west_i | input | DW | West neighbour value |
| east_i | input | DW | East neighbour value |
| north_i | input | DW | North neighbour value |
| south_i | input | DW | South neighbour value |
| speed_i | input | DW | Speed F of the node |
| edge_i | input | 4 | Neighbour-beyond-edge mask (bit 0 W, 1 E, 2 N, 3 S) |
| grow_i | input | 1 | 0: subtract the scaled norm, 1: add it |
| vld_o | output | 1 | Result is valid |
| value_o | output | DW | Next value of the node |

## Verification
The first patterns place all neighbours at the centre value and then above it. These confirm that a flat or locally minimal node does not move, which separates correct clipping from a signed difference. Single large neighbour gaps are then presented, each masked and unmasked by its own edge bit. This shows both which term the maximum picks and that each mask bit reaches the matching neighbour. Products whose low FRAC bits land just under, exactly at and just over one half tell half-up rounding apart from truncation. Full-scale speeds in both directions drive the result past 0 and past 4095, which separates saturation from wrap-around.

A long randomized stream follows, with neighbours close to the centre, random masks and valid gaps. It is applied at the same time to a four-stage and a one-stage instance, so any dependence of the values on the depth, and any latency slip, shows up against the shared model.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int unsigned NBR_COUNT = 4;

    typedef enum logic [1:0] {
        SIDE_WEST  = 2'd0,
        SIDE_EAST  = 2'd1,
        SIDE_NORTH = 2'd2,
        SIDE_SOUTH = 2'd3
    } side_e;

    localparam int unsigned DEF_DATA_W = 12;
    localparam int unsigned DEF_FRAC_W = 8;
    localparam int unsigned DEF_STAGES = 4;

endpackage

// File: rtl/lsu_diff.sv
module lsu_diff #(
    parameter int unsigned DW    = 12,
    parameter int unsigned LANES = 4
) (
    input  logic [DW-1:0]             centre_i,
    input  logic [LANES-1:0][DW-1:0]  nbr_i,
    input  logic [LANES-1:0]          edge_i,
    output logic [LANES-1:0][DW-1:0]  term_o
);

    localparam int unsigned EW = DW + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [EW-1:0] gap;

        always_comb begin
            gap = {1'b0, centre_i} - {1'b0, nbr_i[g]};
            if (edge_i[g] || gap[EW-1]) begin
                term_o[g] = '0;
            end else begin
                term_o[g] = gap[DW-1:0];
            end
        end
    end

endmodule

// File: rtl/lsu_norm.sv
module lsu_norm #(
    parameter int unsigned DW    = 12,
    parameter int unsigned LANES = 4
) (
    input  logic [LANES-1:0][DW-1:0] term_i,
    output logic [DW-1:0]            norm_o
);

    always_comb begin
        norm_o = '0;
        for (int k = 0; k < LANES; k++) begin
            if (term_i[k] > norm_o) begin
                norm_o = term_i[k];
            end
        end
    end

endmodule

// File: rtl/lsu_combine.sv
module lsu_combine #(
    parameter int unsigned DW   = 12,
    parameter int unsigned FRAC = 8
) (
    input  logic [DW-1:0] centre_i,
    input  logic [DW-1:0] speed_i,
    input  logic [DW-1:0] norm_i,
    input  logic          grow_i,
    output logic [DW-1:0] next_o
);

    localparam int unsigned PW   = 2 * DW;
    localparam int unsigned BW   = DW + FRAC;
    localparam int unsigned AW   = ((BW > PW) ? BW : PW) + 2;
    localparam logic signed [AW-1:0] HALF = (AW'(1) << FRAC) >>> 1;
    localparam logic signed [AW-1:0] TOP  = (AW'(1) << DW) - AW'(1);

    logic [PW-1:0]          prod;
    logic signed [AW-1:0]   base;
    logic signed [AW-1:0]   delta;
    logic signed [AW-1:0]   acc;
    logic signed [AW-1:0]   scaled;

    always_comb begin
        prod  = {{DW{1'b0}}, speed_i} * {{DW{1'b0}}, norm_i};
        base  = AW'(centre_i) <<< FRAC;
        delta = AW'(prod);
        if (grow_i) begin
            acc = base + delta + HALF;
        end else begin
            acc = base - delta + HALF;
        end
        scaled = acc >>> FRAC;
        if (scaled < 0) begin
            next_o = '0;
        end else if (scaled > TOP) begin
            next_o = TOP[DW-1:0];
        end else begin
            next_o = scaled[DW-1:0];
        end
    end

endmodule

// File: rtl/lsu_pipe.sv
module lsu_pipe #(
    parameter int unsigned DW     = 12,
    parameter int unsigned STAGES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] val_i,
    output logic          vld_o,
    output logic [DW-1:0] val_o
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] val;
    } slot_t;

    slot_t [STAGES-1:0] pipe_d;
    slot_t [STAGES-1:0] pipe_q;

    always_comb begin
        pipe_d[0].vld = vld_i;
        pipe_d[0].val = val_i;
        for (int k = 1; k < STAGES; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign vld_o = pipe_q[STAGES-1].vld;
    assign val_o = pipe_q[STAGES-1].val;

    // Occupancy tracker used only by the checks below.
    localparam int unsigned CW = $clog2(STAGES + 1) + 1;
    logic [CW-1:0] fill_d;
    logic [CW-1:0] fill_q;

    always_comb begin
        fill_d = fill_q + CW'(vld_i) - CW'(vld_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CW'(STAGES)); // R7
    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (fill_q != '0)); // R7

endmodule

// File: rtl/lsu_node_update.sv
module lsu_node_update
    import lsu_pkg::*;
#(
    parameter int unsigned DW     = DEF_DATA_W,
    parameter int unsigned FRAC   = DEF_FRAC_W,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] centre_i,
    input  logic [DW-1:0] west_i,
    input  logic [DW-1:0] east_i,
    input  logic [DW-1:0] north_i,
    input  logic [DW-1:0] south_i,
    input  logic [DW-1:0] speed_i,
    input  logic [3:0]    edge_i,
    input  logic          grow_i,
    output logic          vld_o,
    output logic [DW-1:0] value_o
);

    logic [NBR_COUNT-1:0][DW-1:0] nbr;
    logic [NBR_COUNT-1:0][DW-1:0] term;
    logic [DW-1:0]                norm;
    logic [DW-1:0]                next_val;

    always_comb begin
        nbr[SIDE_WEST]  = west_i;
        nbr[SIDE_EAST]  = east_i;
        nbr[SIDE_NORTH] = north_i;
        nbr[SIDE_SOUTH] = south_i;
    end

    lsu_diff #(.DW(DW), .LANES(NBR_COUNT)) u_diff (
        .centre_i (centre_i),
        .nbr_i    (nbr),
        .edge_i   (edge_i),
        .term_o   (term)
    );

    lsu_norm #(.DW(DW), .LANES(NBR_COUNT)) u_norm (
        .term_i (term),
        .norm_o (norm)
    );

    lsu_combine #(.DW(DW), .FRAC(FRAC)) u_combine (
        .centre_i (centre_i),
        .speed_i  (speed_i),
        .norm_i   (norm),
        .grow_i   (grow_i),
        .next_o   (next_val)
    );

    lsu_pipe #(.DW(DW), .STAGES(STAGES)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (vld_i),
        .val_i (next_val),
        .vld_o (vld_o),
        .val_o (value_o)
    );

    AST_NORM_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (norm >= term[0]) && (norm >= term[1]) && (norm >= term[2]) && (norm >= term[3])); // R3
    AST_NORM_PICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (norm == term[0]) || (norm == term[1]) || (norm == term[2]) || (norm == term[3])); // R3
    AST_SHRINK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !grow_i |-> (next_val <= centre_i)); // R4
    AST_GROW_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        grow_i |-> (next_val >= centre_i)); // R4
    AST_IDLE_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_i == '0) |-> (next_val == centre_i)); // R6

endmodule

// File: tb/lsu_node_update_bench.sv
`timescale 1ns/1ps
module lsu_node_update_bench;

    localparam int DW      = 12;
    localparam int FRAC    = 8;
    localparam int DEEP    = 4;
    localparam int SHALLOW = 1;
    localparam int TOPV    = (1 << DW) - 1;

    typedef struct {
        bit    vld;
        int    val;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld_i = 1'b0;
    logic [DW-1:0] centre_i = '0, west_i = '0, east_i = '0, north_i = '0, south_i = '0, speed_i = '0;
    logic [3:0]    edge_i = '0;
    logic          grow_i = 1'b0;
    logic          vld_deep, vld_shal;
    logic [DW-1:0] val_deep, val_shal;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    exp_t q_deep[$];
    exp_t q_shal[$];

    always #4 clk = ~clk;

    lsu_node_update #(.DW(DW), .FRAC(FRAC), .STAGES(DEEP)) u_lsu_node_update (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .centre_i(centre_i),
        .west_i(west_i), .east_i(east_i), .north_i(north_i), .south_i(south_i),
        .speed_i(speed_i), .edge_i(edge_i), .grow_i(grow_i),
        .vld_o(vld_deep), .value_o(val_deep));

    lsu_node_update #(.DW(DW), .FRAC(FRAC), .STAGES(SHALLOW)) u_lsu_node_update_s1 (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .centre_i(centre_i),
        .west_i(west_i), .east_i(east_i), .north_i(north_i), .south_i(south_i),
        .speed_i(speed_i), .edge_i(edge_i), .grow_i(grow_i),
        .vld_o(vld_shal), .value_o(val_shal));

    function automatic int ref_next(int c, int w, int e, int n, int s, int f, bit [3:0] em, bit grow);
        int nb[4];
        int nrm = 0;
        longint p, acc;
        nb[0] = w; nb[1] = e; nb[2] = n; nb[3] = s;
        for (int i = 0; i < 4; i++) begin
            int t = c - nb[i];
            if (t < 0) t = 0;
            if (em[i]) t = 0;
            if (t > nrm) nrm = t;
        end
        p   = longint'(f) * longint'(nrm);
        acc = (longint'(c) <<< FRAC) + (grow ? p : -p) + ((longint'(1) <<< FRAC) >>> 1);
        acc = acc >>> FRAC;
        if (acc < 0) acc = 0;
        if (acc > TOPV) acc = TOPV;
        return int'(acc);
    endfunction

    task automatic compare(exp_t e, logic v, logic [DW-1:0] d, string who);
        compared++;
        if (v !== e.vld || (e.vld && d !== DW'(e.val))) begin
            mismatched++;
            $display("FAIL %s %s: got vld=%0b val=%0d, expected vld=%0b val=%0d",
                     e.tag, who, v, d, e.vld, e.val);
        end
    endtask

    task automatic step(bit v, int c, int w, int e, int n, int s, int f, bit [3:0] em, bit grow, string tag);
        exp_t x;
        @(negedge clk);
        compare(q_deep.pop_front(), vld_deep, val_deep, "deep");
        compare(q_shal.pop_front(), vld_shal, val_shal, "shallow");
        vld_i = v; centre_i = DW'(c); west_i = DW'(w); east_i = DW'(e);
        north_i = DW'(n); south_i = DW'(s); speed_i = DW'(f); edge_i = em; grow_i = grow;
        x.vld = v;
        x.val = ref_next(c, w, e, n, s, f, em, grow);
        x.tag = v ? tag : "R7";
        q_deep.push_back(x);
        q_shal.push_back(x);
    endtask

    function automatic int near(int c, int span);
        int r = c + int'($urandom_range(2 * span)) - span;
        if (r < 0) r = 0;
        if (r > TOPV) r = TOPV;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        exp_t idle;
        idle.vld = 0; idle.val = 0; idle.tag = "R9";
        // R9: outputs quiet while reset is held
        repeat (3) begin
            @(negedge clk);
            compared += 2;
            if (vld_deep !== 1'b0 || val_deep !== '0 || vld_shal !== 1'b0 || val_shal !== '0) begin
                mismatched++;
                $display("FAIL R9 reset: got %0b/%0d %0b/%0d, expected 0/0",
                         vld_deep, val_deep, vld_shal, val_shal);
            end
        end
        rst_n = 1'b1;
        for (int i = 0; i < DEEP; i++) q_deep.push_back(idle);
        for (int i = 0; i < SHALLOW; i++) q_shal.push_back(idle);

        // R6: flat neighbourhood and centre below all neighbours keep the value
        step(1, 1000, 1000, 1000, 1000, 1000, 4095, 4'b0000, 0, "R6");
        step(1, 1000, 1200, 1100, 1300, 1050, 4095, 4'b0000, 1, "R1");
        // R1/R3: single gap picks the maximum
        step(1, 2000, 1990, 1500, 1995, 2000, 256, 4'b0000, 0, "R3");
        step(1, 2000, 1990, 2000, 1700, 1950, 256, 4'b0000, 1, "R3");
        // R2: each edge bit masks its own neighbour
        for (int b = 0; b < 4; b++) begin
            int nb[4];
            for (int k = 0; k < 4; k++) nb[k] = 2000;
            nb[b] = 1000;
            step(1, 2000, nb[0], nb[1], nb[2], nb[3], 256, 4'b0001 << b, 0, "R2");
            step(1, 2000, nb[0], nb[1], nb[2], nb[3], 256, 4'b0001 << ((b + 1) % 4), 0, "R2");
        end
        // R4: rounding at, under and over one half
        step(1, 500, 499, 500, 500, 500, 128, 4'b0000, 0, "R4");
        step(1, 500, 499, 500, 500, 500, 128, 4'b0000, 1, "R4");
        step(1, 500, 499, 500, 500, 500, 127, 4'b0000, 1, "R4");
        step(1, 500, 499, 500, 500, 500, 129, 4'b0000, 0, "R4");
        step(1, 500, 497, 500, 500, 500, 300, 4'b0000, 0, "R4");
        // R5: saturation at both ends
        step(1, 4095, 0, 4095, 4095, 4095, 4095, 4'b0000, 0, "R5");
        step(1, 4095, 0, 4095, 4095, 4095, 4095, 4'b0000, 1, "R5");
        step(1, 10, 0, 10, 10, 10, 4095, 4'b0000, 1, "R5");
        step(1, 3000, 2000, 3000, 3000, 3000, 4095, 4'b0000, 0, "R5");
        // R6: zero speed
        step(1, 3000, 0, 1, 2, 3, 0, 4'b0000, 0, "R6");
        // R7: bubbles between valid nodes
        step(0, 3000, 0, 0, 0, 0, 100, 4'b0000, 0, "R7");
        step(1, 1234, 1200, 1234, 1234, 1234, 512, 4'b0000, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 4'b0000, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 4'b0000, 0, "R7");
        // R8: random stream to both depths
        for (int i = 0; i < 3000; i++) begin
            int c = int'($urandom_range(TOPV));
            int sp = (i % 7 == 0) ? TOPV : int'($urandom_range(TOPV));
            step(($urandom_range(3) != 0), c, near(c, 60), near(c, 60), near(c, 60), near(c, 60),
                 sp, 4'($urandom_range(15)) & {4{($urandom_range(2) == 0)}}, 1'($urandom_range(1)), "R8");
        end
        for (int i = 0; i < DEEP + 1; i++) step(0, 0, 0, 0, 0, 0, 0, 4'b0000, 0, "R7");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule